// File: doc/BRIEF.md
# Multi-Channel 3x3 Window Generator

The block accepts a stream of feature-map words, already padded, in which every word carries eight 8-bit channels. Pixels arrive in row-major order. Each pixel is sent as a run of consecutive words, one word per channel group. For every position where a full 3x3 window fits inside the frame, the block presents nine words at once, one on each of nine tap outputs. A downstream multiply-accumulate array can then take a whole kernel's worth of operands in a single transfer.

Two earlier rows are kept in one on-chip line-buffer RAM. Each word of that RAM holds both earlier rows for one column and one channel group. A short history of recent column vectors supplies the two left-hand columns of the window. The frame size and the number of channel groups are sampled when `start` is pulsed. A sticky `last` flag goes high with the final word of the frame.

Top module: `window3x3_gen`

## Requirements
- R1: After reset and before the first `start`, every `m_valid` bit is 0, `s_ready` is 0 and `last` is 0.
- R2: A `start` pulse samples `cfg_rows`, `cfg_cols` and `cfg_groups`, and clears `last` and any pending output. In the cycle after the pulse, `s_ready` is 1 while all taps are ready.
- R3: Tap k (0..8) carries the input word at row `r0 + k/3`, column `c0 + k%3` and the same channel group, where (r0, c0) is the window's top-left pixel. Tap 4 is therefore the centre.
- R4: Windows are emitted in row-major order of their top-left pixel, and all channel groups of one window are emitted consecutively, group 0 first. An H x W frame yields (H-2)*(W-2)*G transfers.
- R5: The first output word becomes valid only once the input word at row 2, column 2, group 0 has been accepted. That is input number (2W+2)*G+1.
- R6: All nine `m_valid` bits are always equal. A transfer takes place only in a cycle where all nine `m_ready` bits are 1. While any ready is low, `m_valid` and `m_data` stay unchanged.
- R7: `last` rises in the same cycle that the final word of the final window appears, and it stays high until the next `start`. Once `last` is high, `s_ready` is 0.
- R8: Word format: byte j (bits 8j+7..8j) of a word in channel group g holds channel 8g+j, on the input and on every tap. Tap k sits at bits 64k+63..64k of `m_data`.
- R9: Any group count from 1 to `MAX_GROUPS`, and any frame of at least 3x3 pixels with `cfg_cols*cfg_groups` no larger than 2^`ADDR_W`, is handled correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new frame; samples the configuration |
| cfg_groups | input | 3 | Channel groups per pixel (1..MAX_GROUPS) |
| cfg_rows | input | 11 | Frame height in pixels, padding included |
| cfg_cols | input | 11 | Frame width in pixels, padding included |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted |
| s_data | input | 64 | Input word, eight channels |
| m_valid | output | 9 | Valid, one bit per tap |
| m_ready | input | 9 | Ready, one bit per tap |
| m_data | output | 576 | Nine tap words, tap k at bits 64k+63..64k |
| last | output | 1 | Final word of the frame reached (sticky) |

## Verification
The embedded assertions check several rules on every cycle. Outputs stay frozen under a partial stall, `last` rises only together with a valid output word, no input is taken once `last` is set, and each `start` carries a legal configuration. The bench's scenarios are needed to show that the tap contents and their order are right. They also show when the first window becomes valid and that the transfer count fits the frame size. Several frame shapes, group counts and backpressure patterns are used for this, including single taps dropping ready.

// File: rtl/window3x3_gen.sv
module window3x3_gen #(
  parameter int DATA_W     = 8,
  parameter int LANES      = 8,
  parameter int MAX_GROUPS = 4,
  parameter int DIM_W      = 11,
  parameter int ADDR_W     = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [$clog2(MAX_GROUPS+1)-1:0] cfg_groups,
  input  logic [DIM_W-1:0]            cfg_rows,
  input  logic [DIM_W-1:0]            cfg_cols,
  input  logic                        s_valid,
  output logic                        s_ready,
  input  logic [DATA_W*LANES-1:0]     s_data,
  output logic [8:0]                  m_valid,
  input  logic [8:0]                  m_ready,
  output logic [9*DATA_W*LANES-1:0]   m_data,
  output logic                        last
);
  localparam int WORD_W = DATA_W * LANES;
  localparam int GRP_W  = $clog2(MAX_GROUPS + 1);
  localparam int TAPS   = 9;
  localparam int HIST   = 2 * MAX_GROUPS;
  localparam int HIX_W  = $clog2(HIST);
  localparam int DEPTH  = 1 << ADDR_W;

  logic [2*WORD_W-1:0] lbuf [DEPTH];
  logic [3*WORD_W-1:0] hist [HIST];
  logic [WORD_W-1:0]   tap_q [TAPS];
  logic [WORD_W-1:0]   tap_d [TAPS];

  logic [ADDR_W-1:0] addr;
  logic [GRP_W-1:0]  grp, n_grp;
  logic [DIM_W-1:0]  row, col, n_rows, n_cols;
  logic              busy, ov, done_q;

  wire all_ready = &m_ready;
  wire pop       = ov && all_ready;
  assign s_ready = busy && !done_q && (!ov || all_ready);
  wire take      = s_valid && s_ready;

  wire [2*WORD_W-1:0] above = lbuf[addr];
  wire [3*WORD_W-1:0] colv  = {above[2*WORD_W-1:WORD_W], above[WORD_W-1:0], s_data};

  wire [GRP_W:0] d1_full = {1'b0, n_grp} - 1'b1;
  wire [GRP_W:0] d2_full = {n_grp, 1'b0} - 1'b1;
  wire [HIX_W-1:0] d1 = d1_full[HIX_W-1:0];
  wire [HIX_W-1:0] d2 = d2_full[HIX_W-1:0];

  wire g_end  = (grp == n_grp - 1'b1);
  wire c_end  = (col == n_cols - 1'b1);
  wire r_end  = (row == n_rows - 1'b1);
  wire win_ok = (row >= 2) && (col >= 2);

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam int RO = k / 3;
    localparam int CO = k % 3;
    logic [3*WORD_W-1:0] cv;
    if (CO == 2) begin : g_now
      assign cv = colv;
    end else if (CO == 1) begin : g_one
      assign cv = hist[d1];
    end else begin : g_two
      assign cv = hist[d2];
    end
    assign tap_d[k] = cv[(2-RO)*WORD_W +: WORD_W];
    assign m_data[k*WORD_W +: WORD_W] = tap_q[k];
  end

  assign m_valid = {TAPS{ov}};
  assign last    = done_q;

  always_ff @(posedge clk) begin
    if (take) begin
      lbuf[addr] <= {above[WORD_W-1:0], s_data};
      hist[0] <= colv;
      for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
      if (win_ok)
        for (int k = 0; k < TAPS; k++) tap_q[k] <= tap_d[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; ov <= 1'b0; done_q <= 1'b0;
      grp <= '0; col <= '0; row <= '0; addr <= '0;
      n_grp <= '0; n_rows <= '0; n_cols <= '0;
    end else if (start) begin
      busy <= 1'b1; ov <= 1'b0; done_q <= 1'b0;
      grp <= '0; col <= '0; row <= '0; addr <= '0;
      n_grp <= cfg_groups; n_rows <= cfg_rows; n_cols <= cfg_cols;
    end else begin
      if (pop) ov <= 1'b0;
      if (take) begin
        if (win_ok) begin
          ov <= 1'b1;
          if (g_end && c_end && r_end) done_q <= 1'b1;
        end
        if (g_end) begin
          grp <= '0;
          if (c_end) begin
            col  <= '0;
            addr <= '0;
            if (r_end) busy <= 1'b0;
            else       row <= row + 1'b1;
          end else begin
            col  <= col + 1'b1;
            addr <= addr + 1'b1;
          end
        end else begin
          grp  <= grp + 1'b1;
          addr <= addr + 1'b1;
        end
      end
    end
  end

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ov && !all_ready && !start) |=> (ov && $stable(m_data)));

  assert_no_take_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> !s_ready);

  assert_last_with_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(last) |-> m_valid[0]);

  assert_cfg_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cfg_groups >= 1 && cfg_groups <= MAX_GROUPS && cfg_rows >= 3 && cfg_cols >= 3
               && ({{ADDR_W{1'b0}}, cfg_cols} * cfg_groups <= DEPTH)));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ov) |-> (!s_ready && m_valid == 9'd0));
endmodule

// File: tb/sim_window3x3_gen.sv
module sim_window3x3_gen;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 150000;
  localparam int NCASE      = 5;
  localparam int ROWS  [NCASE] = '{3, 4, 5, 3, 6};
  localparam int COLS  [NCASE] = '{3, 5, 4, 6, 3};
  localparam int GRPS  [NCASE] = '{1, 2, 3, 4, 1};
  localparam int STALL [NCASE] = '{0, 1, 1, 0, 1};

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] cfg_groups = 0;
  logic [10:0] cfg_rows = 0, cfg_cols = 0;
  logic s_valid = 0, s_ready;
  logic [63:0] s_data = 0;
  logic [8:0] m_valid, m_ready = 0;
  logic [575:0] m_data;
  logic last;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  window3x3_gen u0 (.clk(clk), .rst_n(rst_n), .start(start), .cfg_groups(cfg_groups),
    .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .last(last));

  function automatic logic [63:0] word_at(int r, int c, int g);
    logic [63:0] w;
    for (int j = 0; j < 8; j++) w[j*8 +: 8] = 8'((r*37 + c*11 + (g*8+j)*5 + 1) & 255);
    return w;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_case(int R, int C, int G, int stall);
    int total_in, total_out, in_idx, out_idx, cyc;
    bit first_seen, held;
    logic [575:0] held_data;
    total_in = R*C*G; total_out = (R-2)*(C-2)*G;
    in_idx = 0; out_idx = 0; cyc = 0; first_seen = 0; held = 0; held_data = '0;
    @(negedge clk);
    cfg_rows = 11'(R); cfg_cols = 11'(C); cfg_groups = 3'(G); start = 1; m_ready = '1;
    @(posedge clk); @(negedge clk);
    start = 0;
    #1;
    check("R7 last cleared by start", 64'(last), 64'd0);
    check("R2 ready after start", 64'(s_ready), 64'd1);
    while (out_idx < total_out && cyc < 20000) begin
      m_ready = (stall != 0 && cyc % 5 == 3) ? ~(9'd1 << (cyc % 9)) : 9'h1FF;
      s_valid = (in_idx < total_in) && !(stall != 0 && cyc % 7 == 2);
      s_data  = word_at(in_idx / (G*C), (in_idx / G) % C, in_idx % G);
      #1;
      if (held) begin
        check("R6 data held under stall", 64'(m_data == held_data), 64'd1);
        held = 0;
      end
      if (m_valid[0] && !first_seen) begin
        first_seen = 1;
        check("R5 first window timing", 64'(in_idx), 64'((2*C+2)*G+1));
      end
      if (m_valid[0] && !(&m_ready)) begin
        held = 1; held_data = m_data;
      end
      if (m_valid[0] && (&m_ready)) begin
        int g, wc, wr;
        g = out_idx % G; wc = (out_idx / G) % (C-2); wr = out_idx / (G*(C-2));
        check("R6 valids equal", 64'(m_valid), 64'h1FF);
        for (int k = 0; k < 9; k++)
          check("R3 R8 tap word", m_data[k*64 +: 64], word_at(wr + k/3, wc + k%3, g));
        check("R7 last with final word", 64'(last), 64'(out_idx == total_out-1));
        out_idx++;
      end
      @(posedge clk);
      if (s_valid && s_ready) in_idx++;
      @(negedge clk);
      cyc++;
    end
    s_valid = 0; m_ready = '1;
    check("R4 R9 output count", 64'(out_idx), 64'(total_out));
    check("R4 input count", 64'(in_idx), 64'(total_in));
    repeat (3) @(negedge clk);
    #1;
    check("R7 last sticky", 64'(last), 64'd1);
    check("R7 no input after last", 64'(s_ready), 64'd0);
    check("R4 no extra output", 64'(m_valid), 64'd0);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_ready = '1;
    repeat (2) @(negedge clk);
    #1;
    check("R1 reset m_valid", 64'(m_valid), 64'd0);
    check("R1 reset s_ready", 64'(s_ready), 64'd0);
    check("R1 reset last", 64'(last), 64'd0);
    for (int i = 0; i < NCASE; i++) run_case(ROWS[i], COLS[i], GRPS[i], STALL[i]);
    run_case(4, 4, 2, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule